// File: doc/BRIEF.md
# RGB to YUV Pixel Converter

This block turns a stream of RGB pixels, one per clock, into Y, U and V components. The arithmetic is fixed-point. Each channel is multiplied by a signed integer weight that carries 13 fractional bits. The three products are summed as signed values and shifted right arithmetically by 13, so the result is rounded down toward minus infinity. A constant offset is added, and the result is saturated to the 8-bit range.

A sender drives `in_valid` high together with a pixel. The matching result appears two clock edges later with `out_valid` high. A new pixel can be accepted on every cycle, with no gaps needed. There is no backpressure. While no valid result is leaving, the output registers keep their last value.

Top module: `rgb_yuv_conv`

## Requirements
- R1: Y equals 16 + ((2104*R + 4130*G + 802*B) >>> 13), where R, G and B are unsigned 8-bit values.
- R2: U equals 128 + ((3598*B - 1217*R - 2382*G) >>> 13), with the products summed as signed values before the shift.
- R3: V equals 128 + ((3598*R - 3015*G - 583*B) >>> 13), with the products summed as signed values before the shift.
- R4: The right shift rounds toward minus infinity, not toward zero. A pure red pixel (255,0,0) gives U = 90, not 91.
- R5: Each output is saturated to 0..255 after the offset is added. With the fixed weights, the reachable outputs are Y 16..235, U 15..239 and V 16..239, and the extremes are met: U = 15 for (255,255,0) and V = 16 for (0,255,255).
- R6: `out_valid` equals `in_valid` from two clock edges earlier, and `out_y`, `out_u` and `out_v` carry the result for that pixel.
- R7: Pixels presented on consecutive cycles are each converted, with no gap or loss.
- R8: While `out_valid` is low, the `out_y`, `out_u` and `out_v` outputs keep the last value they had.
- R9: A synchronous active-high `rst` clears both pipeline valid bits and sets all three outputs to 0. A pixel that is in the pipeline when reset arrives is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel strobe |
| in_r | input | 8 | Red channel, unsigned |
| in_g | input | 8 | Green channel, unsigned |
| in_b | input | 8 | Blue channel, unsigned |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_y | output | 8 | Luma result |
| out_u | output | 8 | Blue-difference chroma result |
| out_v | output | 8 | Red-difference chroma result |

## Verification
The hardest situations to reach are those where the signed sum is negative and not a multiple of 8192. Only there does a floor shift differ from a shift that truncates toward zero, and only there do the lowest chroma codes appear. The bench drives pure primaries and two-channel mixes that push U and V to their negative extremes. It also drives a reset in the middle of a stream, so that a pixel is inside the pipeline when reset arrives, and checks that this pixel never comes out.

// File: rtl/rgb_yuv_pkg.sv
package rgb_yuv_pkg;

  localparam int NUM_CH = 3;

  // Weight for output channel ch (0=Y, 1=U, 2=V) applied to input k (0=R, 1=G, 2=B).
  function automatic int yuv_weight(input int ch, input int k);
    int w;
    w = 0;
    case (ch)
      0: case (k) 0: w = 2104;  1: w = 4130;  default: w = 802;   endcase
      1: case (k) 0: w = -1217; 1: w = -2382; default: w = 3598;  endcase
      default: case (k) 0: w = 3598; 1: w = -3015; default: w = -583; endcase
    endcase
    return w;
  endfunction

  function automatic int yuv_offset(input int ch);
    return (ch == 0) ? 16 : 128;
  endfunction

endpackage

// File: rtl/yuv_dot3.sv
module yuv_dot3 #(
  parameter int PIX_W = 8,
  parameter int ACC_W = 22,
  parameter int W_R   = 0,
  parameter int W_G   = 0,
  parameter int W_B   = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [PIX_W-1:0]        a_r,
  input  logic [PIX_W-1:0]        a_g,
  input  logic [PIX_W-1:0]        a_b,
  output logic signed [ACC_W-1:0] acc
);
  localparam logic signed [ACC_W-1:0] KR = ACC_W'(W_R);
  localparam logic signed [ACC_W-1:0] KG = ACC_W'(W_G);
  localparam logic signed [ACC_W-1:0] KB = ACC_W'(W_B);

  logic signed [ACC_W-1:0] sr, sg, sb, sum_d;

  assign sr = signed'(ACC_W'(a_r));
  assign sg = signed'(ACC_W'(a_g));
  assign sb = signed'(ACC_W'(a_b));

  always_comb begin
    sum_d = (sr * KR) + (sg * KG) + (sb * KB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (en) begin
      acc <= sum_d;
    end
  end
endmodule

// File: rtl/yuv_range_stage.sv
module yuv_range_stage #(
  parameter int PIX_W  = 8,
  parameter int ACC_W  = 22,
  parameter int FRAC_W = 13,
  parameter int OFS    = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] acc,
  output logic [PIX_W-1:0]        q
);
  localparam logic signed [ACC_W-1:0] OFS_S = ACC_W'(OFS);
  localparam logic signed [ACC_W-1:0] MAX_S = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] shifted, biased;
  logic [PIX_W-1:0]        clamped;

  always_comb begin
    shifted = acc >>> FRAC_W;
    biased  = shifted + OFS_S;
    if (biased[ACC_W-1]) begin
      clamped = '0;
    end else if (biased > MAX_S) begin
      clamped = '1;
    end else begin
      clamped = biased[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= clamped;
    end
  end
endmodule

// File: rtl/rgb_yuv_conv.sv
module rgb_yuv_conv #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 13,
  parameter int ACC_W  = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_r,
  input  logic [PIX_W-1:0] in_g,
  input  logic [PIX_W-1:0] in_b,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_y,
  output logic [PIX_W-1:0] out_u,
  output logic [PIX_W-1:0] out_v
);
  import rgb_yuv_pkg::*;

  logic                    mac_vld;
  logic signed [ACC_W-1:0] acc   [NUM_CH];
  logic [PIX_W-1:0]        res   [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      mac_vld   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      mac_vld   <= in_valid;
      out_valid <= mac_vld;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    yuv_dot3 #(
      .PIX_W (PIX_W),
      .ACC_W (ACC_W),
      .W_R   (yuv_weight(ch, 0)),
      .W_G   (yuv_weight(ch, 1)),
      .W_B   (yuv_weight(ch, 2))
    ) i_mac (
      .clk (clk),
      .rst (rst),
      .en  (in_valid),
      .a_r (in_r),
      .a_g (in_g),
      .a_b (in_b),
      .acc (acc[ch])
    );

    yuv_range_stage #(
      .PIX_W  (PIX_W),
      .ACC_W  (ACC_W),
      .FRAC_W (FRAC_W),
      .OFS    (yuv_offset(ch))
    ) i_rng (
      .clk (clk),
      .rst (rst),
      .en  (mac_vld),
      .acc (acc[ch]),
      .q   (res[ch])
    );
  end

  assign out_y = res[0];
  assign out_u = res[1];
  assign out_v = res[2];
endmodule

// File: rtl/rgb_yuv_conv_chk.sv
module rgb_yuv_conv_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_y,
  input logic [PIX_W-1:0] out_u,
  input logic [PIX_W-1:0] out_v
);
  logic [1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= 2'd0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !out_valid); // R9

  AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 2'd1 && !out_valid) |-> ($stable(out_y) && $stable(out_u) && $stable(out_v))); // R8

  AST_Y_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_y >= PIX_W'(16) && out_y <= PIX_W'(235))); // R1

  AST_U_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_u >= PIX_W'(15) && out_u <= PIX_W'(239))); // R2

  AST_V_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_v >= PIX_W'(16) && out_v <= PIX_W'(239))); // R3
endmodule

bind rgb_yuv_conv rgb_yuv_conv_chk #(.PIX_W(PIX_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_y     (out_y),
  .out_u     (out_u),
  .out_v     (out_v)
);

// File: tb/test_rgb_yuv_conv.sv
`timescale 1ns/1ps
module test_rgb_yuv_conv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_r = '0, in_g = '0, in_b = '0;
  logic       out_valid;
  logic [7:0] out_y, out_u, out_v;

  int checks = 0;
  int errors = 0;
  bit primed = 0;
  bit done = 0;

  // Expected-value history: index 0 = driven one cycle ago, 1 = two cycles ago.
  bit      h_vld [2];
  int      h_y [2], h_u [2], h_v [2];
  string   h_note [2];
  int      last_y = 0, last_u = 0, last_v = 0;

  always #2.5 clk = ~clk;

  rgb_yuv_conv i_rgb_yuv_conv (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_y(out_y), .out_u(out_u), .out_v(out_v)
  );

  function automatic int sat8(input int x);
    if (x < 0) return 0;
    if (x > 255) return 255;
    return x;
  endfunction

  function automatic int ref_y(input int r, input int g, input int b);
    return sat8(16 + ((2104*r + 4130*g + 802*b) >>> 13));
  endfunction
  function automatic int ref_u(input int r, input int g, input int b);
    return sat8(128 + ((3598*b - 1217*r - 2382*g) >>> 13));
  endfunction
  function automatic int ref_v(input int r, input int g, input int b);
    return sat8(128 + ((3598*r - 3015*g - 583*b) >>> 13));
  endfunction

  task automatic cmp(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: check the output due now, then drive the next input.
  task automatic step(input bit do_rst, input bit v, input int r, input int g, input int b,
                      input string note);
    @(negedge clk);
    if (primed) begin
      cmp({"R6 valid ", h_note[1]}, int'(out_valid), int'(h_vld[1]));
      if (h_vld[1]) begin
        cmp({"R1 Y ", h_note[1]}, int'(out_y), h_y[1]);
        cmp({"R2 U ", h_note[1]}, int'(out_u), h_u[1]);
        cmp({"R3 V ", h_note[1]}, int'(out_v), h_v[1]);
        last_y = h_y[1]; last_u = h_u[1]; last_v = h_v[1];
      end else begin
        cmp({"R8 hold Y ", h_note[1]}, int'(out_y), last_y);
        cmp({"R8 hold U ", h_note[1]}, int'(out_u), last_u);
        cmp({"R8 hold V ", h_note[1]}, int'(out_v), last_v);
      end
    end
    h_vld[1] = h_vld[0]; h_y[1] = h_y[0]; h_u[1] = h_u[0]; h_v[1] = h_v[0];
    h_note[1] = h_note[0];
    h_vld[0] = v && !do_rst;
    h_y[0] = ref_y(r, g, b); h_u[0] = ref_u(r, g, b); h_v[0] = ref_v(r, g, b);
    h_note[0] = note;
    if (do_rst) begin
      h_vld[1] = 1'b0;
      h_note[1] = {"R9 ", note};
      h_note[0] = {"R9 ", note};
      last_y = 0; last_u = 0; last_v = 0;
      primed = 1;
    end
    rst = do_rst; in_valid = v;
    in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "drain");
  endtask

  task automatic t_reset_state();
    step(1, 0, 0, 0, 0, "reset");
    step(1, 1, 9, 9, 9, "reset");
    drain(); // R9: outputs 0 and valid low after reset
  endtask

  task automatic t_corners();
    step(0, 1, 0, 0, 0, "black");
    step(0, 1, 255, 255, 255, "white");
    step(0, 1, 255, 0, 0, "R4 red floor");
    step(0, 1, 0, 255, 0, "green");
    step(0, 1, 0, 0, 255, "R5 blue U max");
    step(0, 1, 255, 255, 0, "R5 U min");
    step(0, 1, 0, 255, 255, "R5 V min");
    step(0, 1, 128, 64, 200, "mid");
    drain();
    // Explicit R4 value: floor(-37.88) = -38 gives U 90.
    cmp("R4 red U constant", ref_u(255, 0, 0), 90);
    cmp("R5 U min constant", ref_u(255, 255, 0), 15);
  endtask

  task automatic t_stream();
    int s = 32'h1ACE;
    for (int i = 0; i < 40; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7FFFFFFF;
      step(0, 1, (s >> 4) & 255, (s >> 12) & 255, (s >> 20) & 255, "R7 stream");
    end
    drain();
  endtask

  task automatic t_bubbles();
    for (int i = 0; i < 16; i++) begin
      step(0, (i % 3) == 0, i * 15, 255 - i * 7, i * 11, "R8 gaps");
    end
    drain();
  endtask

  task automatic t_mid_reset();
    step(0, 1, 200, 10, 30, "pre");
    step(0, 1, 20, 100, 240, "pre");
    step(1, 1, 5, 5, 5, "mid");
    step(0, 0, 0, 0, 0, "after");
    step(0, 1, 40, 80, 120, "after");
    drain();
  endtask

  initial begin
    h_vld[0] = 0; h_vld[1] = 0;
    h_note[0] = "init"; h_note[1] = "init";
    t_reset_state();
    t_corners();
    t_stream();
    t_bubbles();
    t_mid_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule